// File: doc/BRIEF.md
# Dual 8-bit Reload Timer with PWM Pin

This block holds two 8-bit up-counting timers that run side by side once a split-mode control bit is set. One prescaled tick drives both. Each timer counts up by one on every tick that reaches it. When it passes 0xFF it loads its reload value and raises a sticky overflow flag. A tick that arrives while the count equals the timer's compare value raises a sticky compare flag.

The lead timer is the only one that can reach the pin. Each of its compare and overflow events toggles an output bit. With the output enabled, the pin shows that bit XORed with a polarity level, and the level is captured only when the enable goes from off to on. With the output disabled, the same pin can act as a clock gate for the lead timer. A single-shot trigger lets the lead timer run through exactly one overflow while its run bit is off. The aux timer is internal, has its own run bit and flags, and is never gated.

Software configures the block through a write-only register port. The port has no back-pressure: a write with `wr_en` high is taken at that rising clock edge, and it wins over any counting in the same cycle. There is no read path. Results are seen on the flag outputs and the pin.

Top module: `dual8_tmr`

Register map (`wr_addr`):
- 0: control. bit0 split enable, bit1 lead run, bit2 aux run, bit3 output enable, bit4 polarity, bit5 gate enable, bit6 single-shot trigger (write 1; it is not stored as a control bit).
- 1: prescale select, bits 2:0.
- 2, 3, 4: lead value, lead reload, lead compare.
- 5, 6, 7: aux value, aux reload, aux compare.
- 8: flag clear, write 1s. bit0 lead overflow, bit1 lead compare, bit2 aux overflow, bit3 aux compare.

## Requirements
- R1: While the split-enable bit (control bit0) is 0, neither timer value changes except through a direct value write.
- R2: With prescale select N, a tick occurs every 2^N clock cycles. Writing the prescale register restarts the divider, so the first counting edge is the 2^N-th rising edge after the write.
- R3: On a tick, a running timer below 0xFF increments. At 0xFF it loads its reload value and sets its overflow flag. Without a tick its value holds.
- R4: A tick that arrives while a running timer's value equals its compare value sets that timer's compare flag. A compare value the count never reaches never sets the flag.
- R5: All four flags are zero after reset and stay set until a 1 is written to their bit of the flag-clear register (bit0 lead overflow, bit1 lead compare, bit2 aux overflow, bit3 aux compare). A new event in the same cycle as a clear wins.
- R6: `pin_oe` equals the output-enable bit (control bit3). `pin_out` is 0 while the output is disabled. Otherwise it is the latched polarity XOR a toggle bit that flips once for every lead tick with a compare or overflow event (once if both occur together).
- R7: A control write that takes output enable from 0 to 1 latches polarity (control bit4) and clears the toggle bit, so `pin_out` starts at the polarity level. Polarity changes made while the output stays enabled do not reach the pin.
- R8: With output enable 0 and gate enable (control bit5) 1, lead ticks are blocked while the pin input, after a two-flop synchronizer, equals polarity. Gate enable has no effect while output enable is 1.
- R9: Writing control bit6 as 1 lets the lead timer count with its run bit at 0, up to and including its next overflow, after which it stops. When run is written to 1 in the same write, counting continues past that overflow.
- R10: The aux timer counts only on its own run bit (control bit2), is never gated, and never affects `pin_out`.
- R11: A value-register write in the same cycle as a tick loads the written value and discards that tick's increment or reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, taken at the rising edge |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| pin_in | input | 1 | Pin level from the pad, asynchronous, used for gating |
| pin_out | output | 1 | PWM level driven to the pad |
| pin_oe | output | 1 | Pad output enable |
| lead_ovf_flag | output | 1 | Sticky lead overflow flag |
| lead_cmp_flag | output | 1 | Sticky lead compare flag |
| aux_ovf_flag | output | 1 | Sticky aux overflow flag |
| aux_cmp_flag | output | 1 | Sticky aux compare flag |

## Verification
A register write is visible on `pin_oe` and `pin_out` right after the edge that takes it. A tick's overflow or compare event appears on the flags and the pin toggle after that same edge. A change on `pin_in` starts to gate the lead timer only from the third rising edge after it. The bench keeps a cycle model that steps on every rising edge using the inputs held there, and compares every output at the following falling edge. Directed cases count edges from the write that starts them, including the full 2^N wait after a prescale write.

// File: rtl/dual8_tmr_pkg.sv
package dual8_tmr_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_PSC  = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_LVAL = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_LRLD = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_LCMP = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_XVAL = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_XRLD = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_XCMP = 4'd7;
  localparam logic [ADDR_W-1:0] ADR_FCLR = 4'd8;

  localparam int SHOT_BIT = 6;

  // packed: first member is the top bit, split lands on bit0
  typedef struct packed {
    logic gate_en;
    logic pol;
    logic oe;
    logic run_x;
    logic run_l;
    logic split;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic [1:0] {
    FL_LOVF = 2'd0,
    FL_LCMP = 2'd1,
    FL_XOVF = 2'd2,
    FL_XCMP = 2'd3
  } flag_idx_e;
endpackage

// File: rtl/dual8_tmr_psc.sv
module dual8_tmr_psc #(
  parameter int SEL_W = 3,
  localparam int CNT_W = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;

  always_comb begin
    mask = ~({CNT_W{1'b1}} << sel);
    tick = ((cnt & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  AST_PSC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (tick == (sel == '0))); // R2
endmodule

// File: rtl/dual8_tmr_half.sv
module dual8_tmr_half #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          wr_val,
  input  logic          wr_rld,
  input  logic          wr_cmp,
  input  logic [TW-1:0] wdata,
  output logic [TW-1:0] val,
  output logic          ovf_ev,
  output logic          cmp_ev
);
  logic [TW-1:0] rld;
  logic [TW-1:0] cmp;
  logic          at_top;

  always_comb begin
    at_top = (val == {TW{1'b1}});
    ovf_ev = step & at_top;
    cmp_ev = step & (val == cmp);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val <= '0;
      rld <= '0;
      cmp <= '0;
    end else begin
      if (wr_val)    val <= wdata;
      else if (step) val <= at_top ? rld : val + 1'b1;
      if (wr_rld) rld <= wdata;
      if (wr_cmp) cmp <= wdata;
    end
  end

  AST_OVF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev && !wr_val |=> val == $past(rld)); // R3
  AST_NO_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step && !wr_val |=> $stable(val)); // R3
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_val |=> val == $past(wdata)); // R11
endmodule

// File: rtl/dual8_tmr_pin.sv
module dual8_tmr_pin #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  input  logic oe,
  input  logic pol,
  input  logic gate_en,
  input  logic arm,
  input  logic arm_pol,
  input  logic flip,
  output logic gate_hold,
  output logic pin_out,
  output logic pin_oe
);
  logic [SYNC-1:0] sync_q;
  logic            lat_pol;
  logic            tog;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC-2:0], pin_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_pol <= 1'b0;
      tog     <= 1'b0;
    end else if (arm) begin
      lat_pol <= arm_pol;
      tog     <= 1'b0;
    end else if (flip) begin
      tog <= ~tog;
    end
  end

  always_comb begin
    gate_hold = ~oe & gate_en & (sync_q[SYNC-1] == pol);
    pin_out   = oe & (lat_pol ^ tog);
    pin_oe    = oe;
  end

  AST_POL_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> pin_out == $past(arm_pol)); // R7
  AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !arm && !flip |=> (pin_out == $past(pin_out)) || (oe != $past(oe))); // R6
endmodule

// File: rtl/dual8_tmr.sv
module dual8_tmr
  import dual8_tmr_pkg::*;
#(
  parameter int TW    = 8,
  parameter int SEL_W = 3,
  parameter int SYNC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              lead_ovf_flag,
  output logic              lead_cmp_flag,
  output logic              aux_ovf_flag,
  output logic              aux_cmp_flag
);
  localparam int NFL = 4;

  ctrl_t            ctrl;
  ctrl_t            ctrl_new;
  logic [SEL_W-1:0] psc_sel;
  logic             shot;
  logic [NFL-1:0]   flags;
  logic [NFL-1:0]   fl_set;
  logic [NFL-1:0]   fl_clr;

  logic wr_ctrl, wr_psc, wr_fclr;
  logic wr_lval, wr_lrld, wr_lcmp, wr_xval, wr_xrld, wr_xcmp;
  logic tick, gate_hold, arm;
  logic lead_step, aux_step;
  logic l_ovf, l_cmp, x_ovf, x_cmp;
  logic [TW-1:0] lead_val, aux_val;

  always_comb begin
    wr_ctrl = wr_en && (wr_addr == ADR_CTRL);
    wr_psc  = wr_en && (wr_addr == ADR_PSC);
    wr_lval = wr_en && (wr_addr == ADR_LVAL);
    wr_lrld = wr_en && (wr_addr == ADR_LRLD);
    wr_lcmp = wr_en && (wr_addr == ADR_LCMP);
    wr_xval = wr_en && (wr_addr == ADR_XVAL);
    wr_xrld = wr_en && (wr_addr == ADR_XRLD);
    wr_xcmp = wr_en && (wr_addr == ADR_XCMP);
    wr_fclr = wr_en && (wr_addr == ADR_FCLR);
    ctrl_new = ctrl_t'(wr_data[CTRL_W-1:0]);
    arm      = wr_ctrl & ctrl_new.oe & ~ctrl.oe;
    lead_step = ctrl.split & tick & (ctrl.run_l | shot) & ~gate_hold;
    aux_step  = ctrl.split & tick & ctrl.run_x;
    fl_set = '0;
    fl_set[FL_LOVF] = l_ovf;
    fl_set[FL_LCMP] = l_cmp;
    fl_set[FL_XOVF] = x_ovf;
    fl_set[FL_XCMP] = x_cmp;
    fl_clr = wr_fclr ? wr_data[NFL-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      psc_sel <= '0;
      shot    <= 1'b0;
      flags   <= '0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_new;
      if (wr_psc)  psc_sel <= wr_data[SEL_W-1:0];
      if (wr_ctrl && wr_data[SHOT_BIT]) shot <= 1'b1;
      else if (l_ovf)                   shot <= 1'b0;
      flags <= (flags & ~fl_clr) | fl_set;
    end
  end

  dual8_tmr_psc #(.SEL_W(SEL_W)) psc_i (
    .clk(clk), .rst_n(rst_n), .restart(wr_psc), .sel(psc_sel), .tick(tick)
  );

  dual8_tmr_half #(.TW(TW)) lead_i (
    .clk(clk), .rst_n(rst_n), .step(lead_step),
    .wr_val(wr_lval), .wr_rld(wr_lrld), .wr_cmp(wr_lcmp),
    .wdata(wr_data[TW-1:0]), .val(lead_val), .ovf_ev(l_ovf), .cmp_ev(l_cmp)
  );

  dual8_tmr_half #(.TW(TW)) aux_i (
    .clk(clk), .rst_n(rst_n), .step(aux_step),
    .wr_val(wr_xval), .wr_rld(wr_xrld), .wr_cmp(wr_xcmp),
    .wdata(wr_data[TW-1:0]), .val(aux_val), .ovf_ev(x_ovf), .cmp_ev(x_cmp)
  );

  dual8_tmr_pin #(.SYNC(SYNC)) pin_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .oe(ctrl.oe), .pol(ctrl.pol), .gate_en(ctrl.gate_en),
    .arm(arm), .arm_pol(ctrl_new.pol), .flip(l_ovf | l_cmp),
    .gate_hold(gate_hold), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  assign lead_ovf_flag = flags[FL_LOVF];
  assign lead_cmp_flag = flags[FL_LCMP];
  assign aux_ovf_flag  = flags[FL_XOVF];
  assign aux_cmp_flag  = flags[FL_XCMP];

  AST_SPLIT_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.split && !wr_lval && !wr_xval |=> $stable(lead_val) && $stable(aux_val)); // R1
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fclr |=> ((flags & $past(flags)) == $past(flags))); // R5
  AST_SHOT_END: assert property (@(posedge clk) disable iff (!rst_n)
    shot && l_ovf && !wr_ctrl |=> !shot); // R9
  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    gate_hold && !wr_lval |=> $stable(lead_val)); // R8
  AST_GATE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.oe |-> !gate_hold); // R8
endmodule

// File: tb/dual8_tmr_tb_top.sv
module dual8_tmr_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pin_in = 1'b0;
  logic       pin_out, pin_oe;
  logic       lead_ovf_flag, lead_cmp_flag, aux_ovf_flag, aux_cmp_flag;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit chk_on = 1'b0;

  always #10 clk = ~clk;

  dual8_tmr dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .lead_ovf_flag(lead_ovf_flag), .lead_cmp_flag(lead_cmp_flag),
    .aux_ovf_flag(aux_ovf_flag), .aux_cmp_flag(aux_cmp_flag)
  );

  // reference model, stepped on each rising edge from the requirements
  bit [6:0] m_pc;
  bit [2:0] m_sel;
  bit [5:0] m_ctrl;
  bit       m_shot, m_lpol, m_tog, m_s1, m_s2;
  bit [7:0] m_lv, m_lr, m_lc, m_xv, m_xr, m_xc;
  bit [3:0] m_fl;

  function automatic bit [6:0] div_mask(input bit [2:0] s);
    return 7'((8'd1 << s) - 8'd1);
  endfunction

  function automatic bit [7:0] next_val(input bit [7:0] v, input bit [7:0] r);
    return (v == 8'hFF) ? r : v + 8'd1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = '0; m_sel = '0; m_ctrl = '0; m_shot = 0; m_lpol = 0; m_tog = 0;
      m_s1 = 0; m_s2 = 0; m_lv = '0; m_lr = '0; m_lc = '0;
      m_xv = '0; m_xr = '0; m_xc = '0; m_fl = '0;
    end else begin
      bit tk, gt, ls, xs, lo, lcm, xo, xcm;
      bit [3:0] clr;
      tk  = ((m_pc & div_mask(m_sel)) == div_mask(m_sel));
      gt  = !m_ctrl[3] && m_ctrl[5] && (m_s2 == m_ctrl[4]);
      ls  = m_ctrl[0] && tk && (m_ctrl[1] || m_shot) && !gt;
      xs  = m_ctrl[0] && tk && m_ctrl[2];
      lo  = ls && (m_lv == 8'hFF);
      lcm = ls && (m_lv == m_lc);
      xo  = xs && (m_xv == 8'hFF);
      xcm = xs && (m_xv == m_xc);
      if (wr_en && wr_addr == 4'd1) begin m_pc = '0; m_sel = wr_data[2:0]; end
      else m_pc = m_pc + 7'd1;
      if (wr_en && wr_addr == 4'd2) m_lv = wr_data; else if (ls) m_lv = next_val(m_lv, m_lr);
      if (wr_en && wr_addr == 4'd5) m_xv = wr_data; else if (xs) m_xv = next_val(m_xv, m_xr);
      if (wr_en && wr_addr == 4'd3) m_lr = wr_data;
      if (wr_en && wr_addr == 4'd4) m_lc = wr_data;
      if (wr_en && wr_addr == 4'd6) m_xr = wr_data;
      if (wr_en && wr_addr == 4'd7) m_xc = wr_data;
      clr = (wr_en && wr_addr == 4'd8) ? wr_data[3:0] : 4'd0;
      m_fl = (m_fl & ~clr) | {xcm, xo, lcm, lo};
      if (wr_en && wr_addr == 4'd0 && wr_data[6]) m_shot = 1;
      else if (lo) m_shot = 0;
      if (wr_en && wr_addr == 4'd0 && wr_data[3] && !m_ctrl[3]) begin
        m_lpol = wr_data[4]; m_tog = 0;
      end else if (lo || lcm) m_tog = ~m_tog;
      if (wr_en && wr_addr == 4'd0) m_ctrl = wr_data[5:0];
      m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && chk_on && !done) begin
      check("R3 R4 R5 R11 flags vs model",
            int'({aux_cmp_flag, aux_ovf_flag, lead_cmp_flag, lead_ovf_flag}), int'(m_fl));
      check("R6 pin_oe vs model", int'(pin_oe), int'(m_ctrl[3]));
      check("R6 R7 pin_out vs model", int'(pin_out), int'(m_ctrl[3] & (m_lpol ^ m_tog)));
    end
  end

  task automatic wr(input bit [3:0] a, input bit [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    idle(3);
    // reset state
    check("R5 flags zero in reset", int'({aux_cmp_flag, aux_ovf_flag, lead_cmp_flag, lead_ovf_flag}), 0);
    check("R6 pin_oe low in reset", int'(pin_oe), 0);
    rst_n = 1'b1;
    chk_on = 1'b1;
    idle(2);

    // R1: split off blocks counting
    wr(4'd0, 8'h02); wr(4'd1, 8'h00); wr(4'd3, 8'hFE); wr(4'd2, 8'hFE); wr(4'd8, 8'h0F);
    idle(20);
    check("R1 no overflow with split off", int'(lead_ovf_flag), 0);
    wr(4'd0, 8'h03);
    idle(5);
    check("R1 R3 overflow once split on", int'(lead_ovf_flag), 1);

    // R2: divide by 128, first count 128 edges after the prescale write
    wr(4'd0, 8'h00); wr(4'd2, 8'hFF); wr(4'd8, 8'h0F);
    wr(4'd1, 8'h07); wr(4'd0, 8'h03);
    idle(126);
    check("R2 no tick before 2^N edges", int'(lead_ovf_flag), 0);
    idle(1);
    check("R2 tick at 2^N-th edge", int'(lead_ovf_flag), 1);

    // R9: single shot
    wr(4'd0, 8'h00); wr(4'd1, 8'h00); wr(4'd3, 8'hFD); wr(4'd2, 8'hFD); wr(4'd8, 8'h0F);
    wr(4'd0, 8'h41);
    idle(2);
    check("R9 shot not yet overflowed", int'(lead_ovf_flag), 0);
    idle(1);
    check("R9 shot overflow", int'(lead_ovf_flag), 1);
    wr(4'd8, 8'h01);
    idle(20);
    check("R9 shot stops after overflow", int'(lead_ovf_flag), 0);
    wr(4'd0, 8'h43); wr(4'd8, 8'h01);
    idle(20);
    check("R9 shot with run keeps counting", int'(lead_ovf_flag), 1);

    // R6 R7: polarity latch
    wr(4'd0, 8'h00);
    check("R6 pin low with output off", int'(pin_out), 0);
    wr(4'd0, 8'h19);
    check("R7 start at polarity 1", int'(pin_out), 1);
    check("R6 pin_oe follows enable", int'(pin_oe), 1);
    wr(4'd0, 8'h09);
    check("R7 polarity change ignored while enabled", int'(pin_out), 1);
    wr(4'd0, 8'h01);
    check("R6 pin low after disable", int'(pin_out), 0);
    wr(4'd0, 8'h09);
    check("R7 new polarity at re-enable", int'(pin_out), 0);

    // R8 R10: gating
    wr(4'd0, 8'h00); pin_in = 1'b0;
    wr(4'd3, 8'hF0); wr(4'd2, 8'hF0); wr(4'd6, 8'hF0); wr(4'd5, 8'hF0); wr(4'd8, 8'h0F);
    wr(4'd0, 8'h27);
    idle(40);
    check("R8 lead gated while pin equals polarity", int'(lead_ovf_flag), 0);
    check("R10 aux not gated", int'(aux_ovf_flag), 1);
    check("R10 aux leaves pin low", int'(pin_out), 0);
    pin_in = 1'b1;
    idle(30);
    check("R8 lead runs when pin differs", int'(lead_ovf_flag), 1);
    pin_in = 1'b0;
    wr(4'd0, 8'h2F); wr(4'd2, 8'hF0); wr(4'd8, 8'h0F);
    idle(30);
    check("R8 gate ignored with output on", int'(lead_ovf_flag), 1);

    // R4: compare in and out of range
    wr(4'd0, 8'h00); wr(4'd3, 8'hF0); wr(4'd2, 8'hF0); wr(4'd4, 8'hF5); wr(4'd8, 8'h0F);
    wr(4'd0, 8'h03);
    idle(10);
    check("R4 compare hit", int'(lead_cmp_flag), 1);
    wr(4'd0, 8'h00); wr(4'd4, 8'h10); wr(4'd8, 8'h0F); wr(4'd0, 8'h03);
    idle(40);
    check("R4 unreachable compare never hits", int'(lead_cmp_flag), 0);
    check("R3 overflow still occurs", int'(lead_ovf_flag), 1);

    // random phase, checked cycle by cycle against the model
    for (int c = 0; c < 20000; c++) begin
      if ($urandom_range(7) == 0) begin
        bit [3:0] a;
        bit [7:0] d;
        a = 4'($urandom_range(8));
        d = 8'($urandom);
        if (a == 4'd0 && $urandom_range(7) != 0) d[0] = 1'b1;
        if (a == 4'd1) d = 8'($urandom_range(3));
        wr_en = 1'b1; wr_addr = a; wr_data = d;
      end else begin
        wr_en = 1'b0;
      end
      if ($urandom_range(15) == 0) pin_in = ~pin_in;
      @(negedge clk);
    end
    wr_en = 1'b0;
    idle(2);
    finish_run();
  end
endmodule